// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the slave side of a byte-addressed serial memory reached over a four-wire SPI link with a HOLD pause pin. It takes SCK, CS, HOLD and SI as levels synchronous to a fast system clock and finds their edges itself. Each chip-select window carries exactly one command. The first byte is an opcode. The single-byte commands set or clear the write-enable flag. The status commands read or write one status byte. The data commands take a 24-bit address and then stream bytes into or out of a small internal byte-wide array, with an address counter that steps after every byte and wraps at the top.

Whether a write may proceed is decided outside the block. The block shows the target address on `cur_addr` and the status byte on `status`, and a protection unit answers on `wr_allow`. SO is a plain data output with a separate enable, so the pad can build the tri-state driver. The SCK level seen when CS falls is reported on `mode_hi`: low means idle-low clocking (mode 0) and high means idle-high clocking (mode 3).

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, `so_oe` is 0, `status` is 00h, `cur_addr` is 0 and `mode_hi` is 0.
- R2: `mode_hi` takes the SCK level at the CS falling edge and holds it for the whole window. In both modes SI is sampled on rising SCK edges and SO changes on falling SCK edges.
- R3: Opcode 06h sets status bit 1 (write-enable flag). Opcode 04h clears it.
- R4: Opcode 05h shifts out the status byte MSB first. Opcode 01h takes one byte MSB first and, when `wr_allow` is high at its last bit, loads status bits 7..2 and 0 from it while bit 1 is kept. Outside a window, status never changes.
- R5: Opcodes 03h (read) and 02h (write) take three address bytes, MSB first. Only the low ADDR_W bits of the 24-bit address are used.
- R6: After every data byte of a read or write, the address counter steps by one, whether or not the byte was stored. From 2^ADDR_W-1 it wraps to 0, and streaming goes on until CS rises.
- R7: A write data byte reaches the array at its eighth rising SCK edge, and only if `wr_allow` is high then. `cur_addr` shows the target address while the byte is shifted in.
- R8: A byte cut short by CS rising is discarded and never reaches the array.
- R9: Once a command has been taken, later bytes in the same window do not start another command.
- R10: An unknown opcode is ignored: no state changes and `so_oe` stays 0 until CS rises.
- R11: `so_oe` is 1 only while read data or the status byte is being shifted out.
- R12: While HOLD is low, SCK and CS edges are ignored, the shift state is frozen and `so_oe` is 0. The transfer resumes intact when HOLD returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock level |
| cs_n | input | 1 | Chip select, active low |
| hold_n | input | 1 | Pause, active low |
| si | input | 1 | Serial data in |
| wr_allow | input | 1 | Protection verdict for the current address and status writes |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the SO pad driver |
| cur_addr | output | ADDR_W | Current array address |
| status | output | 8 | Status byte; bit 1 is the write-enable flag |
| mode_hi | output | 1 | SCK level captured at CS fall (1 = idle-high clocking) |

## Verification
Each input edge is found by comparing the pin level with its value one clock earlier. A rising SCK edge that ends a byte therefore updates status, the address counter and the array at the first clock edge after SCK rises. SO takes its next bit at the first clock edge after SCK falls. The output enable drops at once when HOLD goes low, and one clock after CS rises. The bench holds each SCK level for two clocks and reads SO at the rising SCK edge, two clocks after the fall that set it. Port-level checks of status and address are made at least two clocks after the last edge of a window.

// File: rtl/spi_mem_pkg.sv
// Shared opcodes, status field position and command phases for the SPI
// serial memory slave. Assumes byte-wide commands, sent MSB first.
package spi_mem_pkg;
    localparam logic [7:0] OP_SET_WE   = 8'h06;
    localparam logic [7:0] OP_CLR_WE   = 8'h04;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_MEM_RD   = 8'h03;
    localparam logic [7:0] OP_MEM_WR   = 8'h02;
    localparam int         WE_FLAG_BIT = 1;
    localparam int         ADDR_BYTES  = 3;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_STAT_RD,
        PH_STAT_WR,
        PH_IGNORE
    } phase_t;
endpackage

// File: rtl/spi_pin_front.sv
// Pin front end: finds SCK edges and chip-select window boundaries in the
// system clock domain and captures the clock idle level at window start.
// Assumes sck, cs_n and hold_n are already synchronous to clk.
// While hold_n is low no edge or boundary is reported.
module spi_pin_front (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_n,
    output logic sel,
    output logic mode_hi,
    output logic frm_start,
    output logic frm_end,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;
    logic live;

    // Previous SCK level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign live      = hold_n && sel && !cs_n;
    assign sck_rise  = live && sck && !sck_q;
    assign sck_fall  = live && !sck && sck_q;
    assign frm_start = hold_n && !sel && !cs_n;
    assign frm_end   = hold_n && sel && cs_n;

    // Window state and clock idle level captured at its opening.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel     <= 1'b0;
            mode_hi <= 1'b0;
        end else if (frm_start) begin
            sel     <= 1'b1;
            mode_hi <= sck;
        end else if (frm_end) begin
            sel     <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
// Command engine: collects bits into bytes, decodes the opcode, gathers the
// address, steps the address counter and drives the SO bit and its enable.
// Assumes one command per window; the phase restarts at every window edge.
module spi_cmd_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_start,
    input  logic              frm_end,
    input  logic              sel,
    input  logic              hold_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si,
    input  logic              wr_allow,
    input  logic [7:0]        rd_data,
    output logic              so_q,
    output logic              so_oe,
    output logic              ram_we,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        wr_data,
    output logic [7:0]        status_q
);
    localparam int            CNT_W    = $clog2(ADDR_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST_AB = CNT_W'(ADDR_BYTES - 1);

    phase_t          phase;
    logic [2:0]      bit_cnt;
    logic [6:0]      sh;
    logic [CNT_W-1:0] abyte;
    logic            rd_cmd;
    logic [7:0]      byte_in;
    logic            byte_done;
    logic            tx_phase;
    logic [7:0]      tx;

    assign byte_in   = {sh, si};
    assign byte_done = sck_rise && (bit_cnt == 3'd7);
    assign tx_phase  = (phase == PH_RDATA) || (phase == PH_STAT_RD);
    assign tx        = (phase == PH_STAT_RD) ? status_q : rd_data;
    assign so_oe     = sel && hold_n && tx_phase;
    assign wr_data   = byte_in;
    assign ram_we    = byte_done && (phase == PH_WDATA) && wr_allow;

    // Bit assembly, opcode decode, address counter and status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_OPCODE;
            bit_cnt  <= 3'd0;
            sh       <= 7'd0;
            abyte    <= '0;
            rd_cmd   <= 1'b0;
            addr_q   <= '0;
            status_q <= 8'h00;
        end else if (frm_start || frm_end) begin
            phase   <= PH_OPCODE;
            bit_cnt <= 3'd0;
            abyte   <= '0;
        end else if (sck_rise) begin
            sh      <= {sh[5:0], si};
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_done) begin
                case (phase)
                    PH_OPCODE: begin
                        abyte <= '0;
                        case (byte_in)
                            OP_SET_WE: begin
                                status_q[WE_FLAG_BIT] <= 1'b1;
                                phase <= PH_IGNORE;
                            end
                            OP_CLR_WE: begin
                                status_q[WE_FLAG_BIT] <= 1'b0;
                                phase <= PH_IGNORE;
                            end
                            OP_STAT_RD: phase <= PH_STAT_RD;
                            OP_STAT_WR: phase <= PH_STAT_WR;
                            OP_MEM_RD: begin
                                rd_cmd <= 1'b1;
                                phase  <= PH_ADDR;
                            end
                            OP_MEM_WR: begin
                                rd_cmd <= 1'b0;
                                phase  <= PH_ADDR;
                            end
                            default: phase <= PH_IGNORE;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_q <= ADDR_W'({addr_q, byte_in});
                        abyte  <= abyte + 1'b1;
                        if (abyte == LAST_AB)
                            phase <= rd_cmd ? PH_RDATA : PH_WDATA;
                    end
                    PH_RDATA, PH_WDATA: addr_q <= addr_q + 1'b1;
                    PH_STAT_RD: phase <= PH_IGNORE;
                    PH_STAT_WR: begin
                        if (wr_allow)
                            status_q <= {byte_in[7:2], status_q[WE_FLAG_BIT], byte_in[0]};
                        phase <= PH_IGNORE;
                    end
                    default: phase <= PH_IGNORE;
                endcase
            end
        end
    end

    // Output bit: next bit of the outgoing byte on each falling SCK edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    so_q <= 1'b0;
        else if (sck_fall && tx_phase) so_q <= tx[3'd7 - bit_cnt];
    end
endmodule

// File: rtl/spi_byte_ram.sv
// Behavioural byte array: synchronous write, combinational read.
// Assumes one write per clock; contents are not reset.
module spi_byte_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte when enabled.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/spi_mem_slave.sv
// Top of the SPI serial memory slave: pin front end, command engine and
// byte array. Assumes pins synchronous to clk and SCK slower than clk/4.
module spi_mem_slave #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              hold_n,
    input  logic              si,
    input  logic              wr_allow,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [7:0]        status,
    output logic              mode_hi
);
    logic       frm_sel;
    logic       frm_start;
    logic       frm_end;
    logic       sck_rise;
    logic       sck_fall;
    logic       ram_we;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata;

    spi_pin_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .hold_n   (hold_n),
        .sel      (frm_sel),
        .mode_hi  (mode_hi),
        .frm_start(frm_start),
        .frm_end  (frm_end),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_cmd_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_start(frm_start),
        .frm_end  (frm_end),
        .sel      (frm_sel),
        .hold_n   (hold_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si       (si),
        .wr_allow (wr_allow),
        .rd_data  (ram_rdata),
        .so_q     (so),
        .so_oe    (so_oe),
        .ram_we   (ram_we),
        .addr_q   (cur_addr),
        .wr_data  (ram_wdata),
        .status_q (status)
    );

    spi_byte_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (cur_addr),
        .wdata(ram_wdata),
        .rdata(ram_rdata)
    );
endmodule

// File: rtl/spi_mem_slave_chk.sv
// Property checker for the SPI serial memory slave, bound to its top.
module spi_mem_slave_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              hold_n,
    input logic              so_oe,
    input logic              frm_sel,
    input logic              mode_hi,
    input logic              ram_we,
    input logic              wr_allow,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [7:0]        status
);
    p_hold_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> !so_oe);

    p_oe_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(hold_n)) |-> !so_oe);

    p_mode_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_sel && $past(frm_sel)) |-> $stable(mode_hi));

    p_write_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wr_allow);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

    p_status_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_sel |=> $stable(status));
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .hold_n  (hold_n),
    .so_oe   (so_oe),
    .frm_sel (frm_sel),
    .mode_hi (mode_hi),
    .ram_we  (ram_we),
    .wr_allow(wr_allow),
    .cur_addr(cur_addr),
    .status  (status)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic          hold_n = 1'b1;
    logic          si = 1'b0;
    logic          wr_allow = 1'b1;
    logic          so;
    logic          so_oe;
    logic [AW-1:0] cur_addr;
    logic [7:0]    status;
    logic          mode_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit oe_seen = 1'b0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    logic [7:0] mon_acc = 8'h00;
    int         mon_cnt = 0;

    always #2 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
        .si(si), .wr_allow(wr_allow), .so(so), .so_oe(so_oe),
        .cur_addr(cur_addr), .status(status), .mode_hi(mode_hi)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b);
        sck = 1'b0; si = b; tk(2);
        sck = 1'b1; tk(2);
    endtask

    task automatic byte_x(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_x(b[i]);
    endtask

    task automatic open_frame(input logic m3);
        sck = m3; tk(2);
        cs_n = 1'b0; tk(2);
        oe_seen = 1'b0;
    endtask

    task automatic close_frame(input logic m3);
        sck = m3; tk(2);
        cs_n = 1'b1; tk(4);
    endtask

    task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a);
        byte_x(op); byte_x(a[23:16]); byte_x(a[15:8]); byte_x(a[7:0]);
    endtask

    task automatic push(input logic [7:0] v, input string tag);
        exp_t e;
        e.v = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic write1(input logic m3, input logic [23:0] a, input logic [7:0] d);
        open_frame(m3); cmd_addr(8'h02, a); byte_x(d); close_frame(m3);
    endtask

    task automatic read_stat(input logic [7:0] e, input string tag);
        open_frame(1'b0); byte_x(8'h05); push(e, tag); byte_x(8'h00); close_frame(1'b0);
    endtask

    // Monitor: assembles SO bits on rising SCK while enabled and scores them.
    always @(posedge sck) begin
        if (so_oe) begin
            oe_seen = 1'b1;
            mon_acc = {mon_acc[6:0], so};
            mon_cnt++;
            if (mon_cnt == 8) begin
                mon_cnt = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected output byte", {24'h0, mon_acc}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(mon_acc == e.v, e.tag, {24'h0, mon_acc}, {24'h0, e.v});
                end
            end
        end
    end

    always @(posedge cs_n) if (hold_n) mon_cnt = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tk(4); rst_n = 1'b1; tk(2);
        // R1 reset values
        chk(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
        chk(status == 8'h00, "R1 status", status, 0);
        chk(cur_addr == '0, "R1 cur_addr", cur_addr, 0);
        chk(mode_hi == 1'b0, "R1 mode_hi", mode_hi, 0);

        // R2 idle-high window, R3 write-enable set
        open_frame(1'b1);
        chk(mode_hi == 1'b1, "R2 mode_hi idle-high", mode_hi, 1);
        byte_x(8'h06); close_frame(1'b1);
        chk(status == 8'h02, "R3 flag set", status, 8'h02);
        open_frame(1'b0);
        chk(mode_hi == 1'b0, "R2 mode_hi idle-low", mode_hi, 0);
        close_frame(1'b0);
        read_stat(8'h02, "R4 status read");

        // R5 R7 R6 write stream then read it back in idle-high clocking
        open_frame(1'b0); cmd_addr(8'h02, 24'h000010);
        byte_x(8'hA5); byte_x(8'h3C); byte_x(8'h77);
        chk(oe_seen == 1'b0, "R11 no output during write", oe_seen, 0);
        close_frame(1'b0);
        chk(cur_addr == 9'h013, "R6 address after three bytes", cur_addr, 9'h013);
        open_frame(1'b1); cmd_addr(8'h03, 24'h000010);
        push(8'hA5, "R5 read byte 0"); push(8'h3C, "R6 read byte 1"); push(8'h77, "R2 read byte 2 idle-high");
        byte_x(8'h00); byte_x(8'h00); byte_x(8'h00); close_frame(1'b1);

        // R6 wrap at the top of the array
        open_frame(1'b0); cmd_addr(8'h02, 24'h0001FF); byte_x(8'h11); byte_x(8'h22); close_frame(1'b0);
        chk(cur_addr == 9'h001, "R6 address wrapped", cur_addr, 9'h001);
        open_frame(1'b0); cmd_addr(8'h03, 24'h0001FF);
        push(8'h11, "R6 top byte"); push(8'h22, "R6 wrapped byte");
        byte_x(8'h00); byte_x(8'h00); close_frame(1'b0);

        // R5 upper address bits ignored
        write1(1'b0, 24'hFFFE05, 8'h9A);
        open_frame(1'b0); cmd_addr(8'h03, 24'h000005); push(8'h9A, "R5 high bits ignored");
        byte_x(8'h00); close_frame(1'b0);

        // R7 protected write leaves the array alone but the address steps
        write1(1'b0, 24'h000020, 8'h66);
        wr_allow = 1'b0;
        write1(1'b0, 24'h000020, 8'h55);
        wr_allow = 1'b1;
        chk(cur_addr == 9'h021, "R7 address stepped on blocked byte", cur_addr, 9'h021);
        open_frame(1'b0); cmd_addr(8'h03, 24'h000020); push(8'h66, "R7 blocked write");
        byte_x(8'h00); close_frame(1'b0);

        // R8 partial byte discarded
        write1(1'b0, 24'h000031, 8'h44);
        open_frame(1'b0); cmd_addr(8'h02, 24'h000030); byte_x(8'hAB);
        for (int i = 0; i < 4; i++) bit_x(1'b1);
        close_frame(1'b0);
        open_frame(1'b0); cmd_addr(8'h03, 24'h000030);
        push(8'hAB, "R8 full byte kept"); push(8'h44, "R8 partial byte dropped");
        byte_x(8'h00); byte_x(8'h00); close_frame(1'b0);

        // R9 one command per window
        open_frame(1'b0); byte_x(8'h04); byte_x(8'h06); close_frame(1'b0);
        chk(status[1] == 1'b0, "R9 second opcode ignored", status, 8'h00);
        chk(status[1] == 1'b0, "R3 flag cleared", status, 8'h00);
        open_frame(1'b0); byte_x(8'h06); close_frame(1'b0);

        // R10 unknown opcode
        open_frame(1'b0); byte_x(8'hB9); byte_x(8'h05); byte_x(8'h04); byte_x(8'h00);
        chk(oe_seen == 1'b0, "R10 output stays off", oe_seen, 0);
        close_frame(1'b0);
        chk(status == 8'h02, "R10 status unchanged", status, 8'h02);

        // R4 status write, allowed and blocked
        open_frame(1'b0); byte_x(8'h01); byte_x(8'h8C); close_frame(1'b0);
        chk(status == 8'h8E, "R4 status written with flag kept", status, 8'h8E);
        wr_allow = 1'b0;
        open_frame(1'b0); byte_x(8'h01); byte_x(8'h00); close_frame(1'b0);
        wr_allow = 1'b1;
        read_stat(8'h8E, "R4 blocked status write");

        // R12 hold pauses a read mid-byte
        open_frame(1'b0); cmd_addr(8'h03, 24'h000010);
        push(8'hA5, "R12 byte across hold"); push(8'h3C, "R12 byte after hold");
        bit_x(1'b0); bit_x(1'b0); bit_x(1'b0);
        hold_n = 1'b0; tk(2);
        chk(so_oe == 1'b0, "R12 output off in hold", so_oe, 0);
        sck = 1'b0; tk(2); sck = 1'b1; tk(2); sck = 1'b0; tk(2); sck = 1'b1; tk(2);
        cs_n = 1'b1; tk(2); cs_n = 1'b0; tk(2);
        chk(so_oe == 1'b0, "R12 output off after edges in hold", so_oe, 0);
        hold_n = 1'b1; tk(2);
        for (int i = 0; i < 5; i++) bit_x(1'b0);
        byte_x(8'h00); close_frame(1'b0);

        tk(10);
        chk(exp_q.size() == 0, "R11 all expected bytes produced", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule